// File: doc/BRIEF.md
# Saturating Per-Pin Assertion Counter

This block keeps, for each of 32 interrupt input pins, a count of how many sources currently hold that pin asserted. It does not store a single level bit. Every command names a pin and one of three operations. An assert raises the count by one. A deassert lowers it by one. A pulse performs an assert and then a deassert. The count saturates at both ends. Each bound has its own error code and its own statistics counter, so a faulty source that sends unbalanced transitions can never wrap the count.

The block raises a one-cycle delivery request, tagged with the pin number, only when a pin's count moves from exactly zero to exactly one. It also exports a per-pin "count nonzero" vector. Neighbouring register and end-of-interrupt logic use that vector to decide whether a level-triggered source is still active. Routing and delivery of the interrupt happen outside this block.

Top module: `pin_assert_counter`

## Requirements
- R1: After reset all counts are zero, `pinActive` and both statistics counters are zero, `cmdReady` is high, and `rspValid` and `deliverReq` are low.
- R2: An assert (op code 0) on a count below 255 increments it and responds with error code 0 (OK). Bit p of `pinActive` is high exactly while the count of pin p is nonzero.
- R3: An assert on a count of 255 leaves the count at 255, responds with error code 2 (too big) and adds one to `satHighCount`.
- R4: A deassert (op code 1) on a nonzero count decrements it and responds with error code 0.
- R5: A deassert on a count of zero leaves it at zero, responds with error code 3 (range) and adds one to `satLowCount`.
- R6: `deliverReq` is high for one cycle, with `deliverPin` naming the pin, exactly when a count moves from 0 to 1. A move from 1 to 0, or any other change, raises no request.
- R7: A pulse (op code 2) first performs the assert. The deassert follows only if the assert returned OK. The response carries the first error seen. `cmdReady` is low for the one cycle between the two halves, and the response appears two cycles after acceptance.
- R8: A pin number of 32 or more, or the reserved op code 3, responds with error code 1 (invalid) and changes no count and no statistic.
- R9: Assert, deassert and rejected commands respond with a one-cycle `rspValid` in the cycle after acceptance. Statistics counters are 32 bits wide and wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Block can accept a command |
| cmdOp | input | 2 | 0 assert, 1 deassert, 2 pulse, 3 reserved |
| cmdPin | input | 6 | Target pin number |
| rspValid | output | 1 | One-cycle response strobe |
| rspErr | output | 2 | 0 OK, 1 invalid, 2 too big, 3 range |
| deliverReq | output | 1 | One-cycle request on a 0 to 1 count move |
| deliverPin | output | 5 | Pin of the delivery request |
| pinActive | output | 32 | Per-pin count-nonzero status |
| satHighCount | output | 32 | Number of asserts refused at the upper bound |
| satLowCount | output | 32 | Number of deasserts refused at zero |

## Verification
A wrong count stays hidden until the pin reaches a boundary. Counting one too many or too few shows up later: a deassert returns a range error at the wrong point, `pinActive` drops early or late, or a fresh delivery request goes missing. For that reason the bench tracks every pin's count and compares the error code, the delivery request and the full `pinActive` vector after every command. A fault in the pulse sequencing shows up within two cycles, either as a response arriving at the wrong time or as a net count change that is not zero.

// File: rtl/pin_assert_counter_pkg.sv
package pin_assert_counter_pkg;
  typedef enum logic [1:0] {
    OP_ASSERT   = 2'd0,
    OP_DEASSERT = 2'd1,
    OP_PULSE    = 2'd2,
    OP_RESERVED = 2'd3
  } cmdOp_e;

  typedef enum logic [1:0] {
    ERR_OK      = 2'd0,
    ERR_INVALID = 2'd1,
    ERR_TOOBIG  = 2'd2,
    ERR_RANGE   = 2'd3
  } errCode_e;

  localparam int PIN_IDX_W = 5;

  // strobes from the sequencer to the count store
  typedef struct packed {
    logic                 inc;
    logic                 dec;
    logic [PIN_IDX_W-1:0] pin;
  } cntStrobe_t;
endpackage

// File: rtl/pin_assert_counter_ctrl.sv
module pin_assert_counter_ctrl
  import pin_assert_counter_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int PIN_W    = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [1:0]       cmdOp,
  input  logic [PIN_W-1:0] cmdPin,
  input  logic             selAtMax,
  input  logic             selAtZero,
  output cntStrobe_t       strobe,
  output logic             rspValid,
  output logic [1:0]       rspErr
);
  localparam logic [PIN_W-1:0] PIN_LIMIT = PIN_W'(NUM_PINS);

  typedef enum logic {S_IDLE, S_PULSE2} state_e;

  state_e                 state;
  logic [PIN_IDX_W-1:0]   heldPin;
  errCode_e               firstErr;
  logic                   fire, cmdOk;
  errCode_e               singleErr;

  assign cmdReady = (state == S_IDLE);
  assign fire     = cmdValid && cmdReady;
  assign cmdOk    = (cmdPin < PIN_LIMIT) && (cmdOp != OP_RESERVED);

  always_comb begin
    strobe = '0;
    if (state == S_PULSE2) begin
      strobe.pin = heldPin;
      strobe.dec = (firstErr == ERR_OK);
    end else begin
      strobe.pin = cmdPin[PIN_IDX_W-1:0];
      strobe.inc = fire && cmdOk && (cmdOp == OP_ASSERT || cmdOp == OP_PULSE);
      strobe.dec = fire && cmdOk && (cmdOp == OP_DEASSERT);
    end
  end

  always_comb begin
    if (!cmdOk)                     singleErr = ERR_INVALID;
    else if (cmdOp == OP_DEASSERT)  singleErr = selAtZero ? ERR_RANGE : ERR_OK;
    else                            singleErr = selAtMax ? ERR_TOOBIG : ERR_OK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      heldPin  <= '0;
      firstErr <= ERR_OK;
      rspValid <= 1'b0;
      rspErr   <= 2'd0;
    end else begin
      rspValid <= 1'b0;
      if (state == S_PULSE2) begin
        rspValid <= 1'b1;
        rspErr   <= firstErr;
        state    <= S_IDLE;
      end else if (fire) begin
        if (cmdOk && cmdOp == OP_PULSE) begin
          state    <= S_PULSE2;
          heldPin  <= cmdPin[PIN_IDX_W-1:0];
          firstErr <= singleErr;
        end else begin
          rspValid <= 1'b1;
          rspErr   <= singleErr;
        end
      end
    end
  end
endmodule

// File: rtl/pin_assert_counter_dp.sv
module pin_assert_counter_dp
  import pin_assert_counter_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int CNT_W    = 8,
  parameter int STAT_W   = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cntStrobe_t           strobe,
  output logic                 selAtMax,
  output logic                 selAtZero,
  output logic                 deliverReq,
  output logic [PIN_IDX_W-1:0] deliverPin,
  output logic [NUM_PINS-1:0]  pinActive,
  output logic [STAT_W-1:0]    satHighCount,
  output logic [STAT_W-1:0]    satLowCount
);
  logic [CNT_W-1:0] cnt [NUM_PINS];
  logic [CNT_W-1:0] selCnt;

  assign selCnt    = cnt[strobe.pin];
  assign selAtMax  = (selCnt == {CNT_W{1'b1}});
  assign selAtZero = (selCnt == '0);

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_active
      assign pinActive[g] = |cnt[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PINS; i++) cnt[i] <= '0;
      satHighCount <= '0;
      satLowCount  <= '0;
      deliverReq   <= 1'b0;
      deliverPin   <= '0;
    end else begin
      deliverReq <= strobe.inc && selAtZero;
      deliverPin <= strobe.pin;
      if (strobe.inc) begin
        if (selAtMax) satHighCount <= satHighCount + 1'b1;
        else          cnt[strobe.pin] <= selCnt + 1'b1;
      end else if (strobe.dec) begin
        if (selAtZero) satLowCount <= satLowCount + 1'b1;
        else           cnt[strobe.pin] <= selCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pin_assert_counter.sv
module pin_assert_counter
  import pin_assert_counter_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int PIN_W    = 6,
  parameter int CNT_W    = 8,
  parameter int STAT_W   = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  output logic                 cmdReady,
  input  logic [1:0]           cmdOp,
  input  logic [PIN_W-1:0]     cmdPin,
  output logic                 rspValid,
  output logic [1:0]           rspErr,
  output logic                 deliverReq,
  output logic [PIN_IDX_W-1:0] deliverPin,
  output logic [NUM_PINS-1:0]  pinActive,
  output logic [STAT_W-1:0]    satHighCount,
  output logic [STAT_W-1:0]    satLowCount
);
  cntStrobe_t strobe;
  logic       selAtMax, selAtZero;

  pin_assert_counter_ctrl #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdPin(cmdPin), .selAtMax(selAtMax), .selAtZero(selAtZero),
    .strobe(strobe), .rspValid(rspValid), .rspErr(rspErr)
  );

  pin_assert_counter_dp #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W), .STAT_W(STAT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selAtMax(selAtMax),
    .selAtZero(selAtZero), .deliverReq(deliverReq), .deliverPin(deliverPin),
    .pinActive(pinActive), .satHighCount(satHighCount), .satLowCount(satLowCount)
  );
endmodule

// File: rtl/pin_assert_counter_chk.sv
module pin_assert_counter_chk #(
  parameter int NUM_PINS = 32,
  parameter int PIN_W    = 6,
  parameter int STAT_W   = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdValid,
  input logic                cmdReady,
  input logic [1:0]          cmdOp,
  input logic [PIN_W-1:0]    cmdPin,
  input logic                rspValid,
  input logic [1:0]          rspErr,
  input logic                deliverReq,
  input logic [4:0]          deliverPin,
  input logic [NUM_PINS-1:0] pinActive,
  input logic [STAT_W-1:0]   satHighCount,
  input logic [STAT_W-1:0]   satLowCount
);
  localparam logic [PIN_W-1:0] PIN_LIMIT = PIN_W'(NUM_PINS);

  p_pulse_stalls_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdOp == 2'd2 && cmdPin < PIN_LIMIT) |=> !cmdReady);

  p_ready_at_rsp_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> cmdReady);

  p_single_rsp_next_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdOp != 2'd2) |=> rspValid);

  p_deliver_active_r6: assert property (@(posedge clk) disable iff (!rstN)
    deliverReq |-> pinActive[deliverPin]);

  p_satlow_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(satLowCount) |-> satLowCount == $past(satLowCount) + 1'b1);

  p_sathigh_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(satHighCount) |-> satHighCount == $past(satHighCount) + 1'b1);

  p_invalid_no_change_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr == 2'd1) |-> ($stable(pinActive) && $stable(satLowCount)
                                      && $stable(satHighCount)));
endmodule

bind pin_assert_counter pin_assert_counter_chk #(
  .NUM_PINS(NUM_PINS), .PIN_W(PIN_W), .STAT_W(STAT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdOp(cmdOp), .cmdPin(cmdPin), .rspValid(rspValid), .rspErr(rspErr),
  .deliverReq(deliverReq), .deliverPin(deliverPin), .pinActive(pinActive),
  .satHighCount(satHighCount), .satLowCount(satLowCount)
);

// File: tb/pin_assert_counter_bench.sv
module pin_assert_counter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [1:0]  cmdOp = 2'd0;
  logic [5:0]  cmdPin = 6'd0;
  logic        rspValid;
  logic [1:0]  rspErr;
  logic        deliverReq;
  logic [4:0]  deliverPin;
  logic [31:0] pinActive, satHighCount, satLowCount;

  int          nChecks = 0;
  int          nFails  = 0;
  int          model [32];
  int          mHigh = 0, mLow = 0;

  always #5 clk = ~clk;

  pin_assert_counter u_pin_assert_counter (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdPin(cmdPin), .rspValid(rspValid), .rspErr(rspErr),
    .deliverReq(deliverReq), .deliverPin(deliverPin), .pinActive(pinActive),
    .satHighCount(satHighCount), .satLowCount(satLowCount)
  );

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expActive();
    logic [31:0] v;
    for (int i = 0; i < 32; i++) v[i] = (model[i] != 0);
    return v;
  endfunction

  // R2 R3 R4 R5 R7 R8: expected error code, and model update
  function automatic int applyModel(input int op, input int pin, output bit dlv);
    dlv = 0;
    if (pin >= 32 || op == 3) return 1;
    if (op == 1) begin
      if (model[pin] == 0) begin mLow++; return 3; end
      model[pin]--; return 0;
    end
    if (model[pin] == 255) begin mHigh++; return 2; end
    if (model[pin] == 0) dlv = 1;
    model[pin]++;
    if (op == 2) model[pin]--;
    return 0;
  endfunction

  task automatic runCmd(input int op, input int pin);
    bit dlvExp, dlvSeen;
    int errExp, waitCyc, rspAt;
    errExp = applyModel(op, pin, dlvExp);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op[1:0]; cmdPin = pin[5:0];
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    dlvSeen = 0; waitCyc = 1;
    while (1) begin
      if (deliverReq) dlvSeen = dlvSeen | (deliverPin == pin[4:0]) | 1'b0;
      if (deliverReq && deliverPin != pin[4:0]) check("R6 deliverPin", deliverPin, pin);
      if (rspValid) break;
      if (waitCyc > 4) break;
      @(negedge clk); waitCyc++;
    end
    rspAt = (op == 2 && errExp != 1) ? 2 : 1;
    check(op == 2 ? "R7 rsp latency" : "R9 rsp latency", waitCyc, rspAt);
    check(op == 2 ? "R7 err" : (errExp == 1 ? "R8 err" :
          (op == 0 ? "R3/R2 err" : "R5/R4 err")), rspErr, errExp);
    check("R6 deliverReq", dlvSeen, dlvExp);
    check("R2 pinActive", pinActive, expActive());
    check("R3 satHighCount", satHighCount, mHigh);
    check("R5 satLowCount", satLowCount, mLow);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(10 * 190000);
    nFails++; nChecks++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 ready", cmdReady, 1);
    check("R1 rspValid", rspValid, 0);
    check("R1 deliverReq", deliverReq, 0);
    check("R1 pinActive", pinActive, 0);
    check("R1 stats", satHighCount + satLowCount, 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed corners
    runCmd(1, 7);            // R5 deassert at zero
    runCmd(2, 7);            // R7 pulse from zero: deliver, net zero
    runCmd(0, 31);           // R6 0->1 on top pin
    runCmd(0, 31);           // R6 no request on 1->2
    runCmd(1, 31);
    runCmd(1, 31);           // R6 no request on 1->0
    runCmd(0, 32);           // R8 pin out of range
    runCmd(3, 4);            // R8 reserved op
    runCmd(0, 63);           // R8
    for (int i = 0; i < 255; i++) runCmd(0, 5);
    runCmd(0, 5);            // R3 at 255
    runCmd(2, 5);            // R7 pulse at max: too big, no deassert
    runCmd(1, 5);            // R4 from 255
    runCmd(2, 5);            // R7 pulse below max succeeds
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r, op, pin;
      r  = $urandom_range(0, 99);
      op = (r < 40) ? 0 : (r < 80) ? 1 : (r < 95) ? 2 : 3;
      pin = ($urandom_range(0, 19) == 0) ? $urandom_range(32, 63) : $urandom_range(0, 3);
      runCmd(op, pin);
    end
    finishRun();
  end
endmodule